// File: doc/BRIEF.md
# Variable Pulse-Width Bit Encoder

This block turns a stream of frame bytes into a two-level bus waveform using variable pulse-width encoding. Each data bit is one bus level held for a short or a long interval, and there is exactly one transition per bit. The bus level therefore alternates from bit to bit, and the length of a bit depends on its value and on the level it is sent at. A frame opens with an active start-of-frame symbol of fixed length. The data bits follow, most significant bit first, and a fixed passive end-of-data interval closes the frame before the block will take a new one.

Bytes arrive over a valid/ready handshake that carries a last-byte marker. The first byte of a frame is taken while the block is idle. Each later byte is taken during the final bit of the byte that is on the bus, so consecutive bytes join with no gap. All timing counts a 1 µs enable pulse (`tick_us`). An abort input drops the bus to passive at once and sends the block back to idle.

The controller has four states. IDLE: the bus is passive and `in_ready` is high. SOF: the start-of-frame symbol is on the bus. DATA: data bits are being sent. EOD: the closing passive interval is running. The transitions are: IDLE→SOF when a first byte is accepted; SOF→DATA when the start symbol time expires; DATA→DATA at the end of every bit except the frame's last; DATA→EOD at the end of the last bit, or at the end of a byte when no follow-on byte has arrived; EOD→IDLE when the closing interval expires; any state→IDLE while `abort` is high.

Top module: `vpw_encoder`

## Requirements
- R1: After reset the bus output is passive (0) and `in_ready` is 1 (idle, ready for a first byte).
- R2: Accepting a byte in idle starts the start-of-frame symbol: `bus_active` = 1 for exactly TICKS_SOF (200) ticks.
- R3: The first data bit is passive (`bus_active` = 0). The level then alternates on every bit, so data bit j of a frame (counting from 0) has level j mod 2, with one transition per bit.
- R4: A passive 1 and an active 0 last TICKS_LONG (128) ticks. A passive 0 and an active 1 last TICKS_SHORT (64) ticks.
- R5: Each byte is sent from bit 7 down to bit 0, and bytes are sent in the order they were accepted. A follow-on byte starts right after the previous byte's bit 0, with no added time and with the level alternation continuing.
- R6: While a frame is on the bus, `in_ready` is 1 only during the final bit (bit 0) of the current byte, only if that byte was not marked last, and only until one byte has been taken.
- R7: After the last bit of a frame the bus stays passive, and `in_ready` stays 0 for exactly TICKS_EOD (200) ticks. After that the block is idle again.
- R8: If a byte not marked last ends before a follow-on byte has been accepted, the frame closes as though that byte had been marked last.
- R9: While `abort` is 1, `bus_active` is 0 in the same cycle and `in_ready` is 0. On the next clock the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond; all symbol timing counts it |
| abort | input | 1 | Forces the bus passive and returns the block to idle |
| in_data | input | DATA_W | Byte to transmit |
| in_valid | input | 1 | `in_data` and `in_last` are valid |
| in_last | input | 1 | The offered byte is the last one of the frame |
| in_ready | output | 1 | The block takes the offered byte on this clock |
| bus_active | output | 1 | 1 drives the bus to the active level, 0 leaves it passive |

## Verification
The assertions assume that `tick_us` is never high for two cycles in a row, that `in_data` and `in_last` hold steady while `in_valid` waits for `in_ready`, and that `abort` can arrive in any state. The stimulus drives the tick from a free-running divide-by-two, and changes the data only after a handshake. It raises abort once, partway through a start symbol. Random frames of one to four bytes, with random idle gaps, are mixed with directed all-zero, all-one and alternating-pattern bytes and with a byte-underrun frame. Every observed level segment is compared against the durations computed from the encoding table.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOF  = 2'd1,
        ST_DATA = 2'd2,
        ST_EOD  = 2'd3
    } vpw_state_e;

    // A bit is long when its value differs from the level it is sent at.
    function automatic logic bit_is_long(input logic bit_val, input logic active_lvl);
        return bit_val ^ active_lvl;
    endfunction

endpackage

// File: rtl/vpw_seg_timer.sv
module vpw_seg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    assign expire = tick && !clear && (cnt_q == (limit - CW'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + CW'(1);
        end
    end

    // R4: the running count never passes the length of the current segment
    assert_cnt_within_segment_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q < limit));

endmodule

// File: rtl/vpw_byte_shifter.sv
module vpw_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_first,
    input  logic              bit_done,
    input  logic              hold_accept,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              cur_bit,
    output logic              final_bit,
    output logic              cur_last,
    output logic              hold_full
);

    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] hold_q;
    logic              hold_last_q;
    logic              last_q;
    logic              full_q;
    logic [IW-1:0]     idx_q;

    assign cur_bit   = sh_q[DATA_W-1];
    assign final_bit = (idx_q == IW'(DATA_W - 1));
    assign cur_last  = last_q;
    assign hold_full = full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q        <= '0;
            hold_q      <= '0;
            hold_last_q <= 1'b0;
            last_q      <= 1'b0;
            full_q      <= 1'b0;
            idx_q       <= '0;
        end else if (clear) begin
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (load_first) begin
            sh_q   <= in_data;
            last_q <= in_last;
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (bit_done && final_bit) begin
            idx_q <= '0;
            if (full_q) begin
                sh_q   <= hold_q;
                last_q <= hold_last_q;
                full_q <= 1'b0;
            end else if (hold_accept) begin
                sh_q   <= in_data;
                last_q <= in_last;
            end
        end else begin
            if (bit_done) begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                idx_q <= idx_q + IW'(1);
            end
            if (hold_accept) begin
                hold_q      <= in_data;
                hold_last_q <= in_last;
                full_q      <= 1'b1;
            end
        end
    end

    // R6: a follow-on byte is only taken in the final bit, into an empty holder
    assert_accept_in_final_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_accept |-> (final_bit && !full_q));

    // R5: bits advance one position per finished bit inside a byte
    assert_index_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && !final_bit && !clear) |=> (idx_q == $past(idx_q) + IW'(1)));

endmodule

// File: rtl/vpw_encoder.sv
module vpw_encoder #(
    parameter int DATA_W      = 8,
    parameter int TICKS_SHORT = 64,
    parameter int TICKS_LONG  = 128,
    parameter int TICKS_SOF   = 200,
    parameter int TICKS_EOD   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              abort,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              bus_active
);

    import vpw_pkg::*;

    localparam int MAX_A = (TICKS_SHORT > TICKS_LONG) ? TICKS_SHORT : TICKS_LONG;
    localparam int MAX_B = (TICKS_SOF > TICKS_EOD) ? TICKS_SOF : TICKS_EOD;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_T + 1);

    vpw_state_e    state_q, state_d;
    logic          lvl_q, lvl_d;
    logic [CW-1:0] limit;
    logic          expire;
    logic          tmr_clear;
    logic          bus_drive;
    logic          cur_bit, final_bit, cur_last, hold_full;
    logic          accept_first, hold_accept, bit_done, frame_end;

    vpw_seg_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tick_us),
        .limit  (limit),
        .expire (expire)
    );

    vpw_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (abort),
        .load_first  (accept_first),
        .bit_done    (bit_done),
        .hold_accept (hold_accept),
        .in_data     (in_data),
        .in_last     (in_last),
        .cur_bit     (cur_bit),
        .final_bit   (final_bit),
        .cur_last    (cur_last),
        .hold_full   (hold_full)
    );

    assign accept_first = (state_q == ST_IDLE) && in_valid && in_ready;
    assign hold_accept  = (state_q == ST_DATA) && in_valid && in_ready;
    assign bit_done     = (state_q == ST_DATA) && expire;
    assign frame_end    = final_bit && (cur_last || !(hold_full || hold_accept));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        if (abort) begin
            state_d = ST_IDLE;
            lvl_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid) state_d = ST_SOF;
                ST_SOF: begin
                    if (expire) begin
                        state_d = ST_DATA;
                        lvl_d   = 1'b0;
                    end
                end
                ST_DATA: begin
                    if (expire) begin
                        lvl_d = ~lvl_q;
                        if (frame_end) state_d = ST_EOD;
                    end
                end
                ST_EOD: if (expire) state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        limit     = CW'(TICKS_SOF);
        in_ready  = 1'b0;
        bus_drive = 1'b0;
        tmr_clear = abort;
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = !abort;
                tmr_clear = 1'b1;
            end
            ST_SOF: begin
                limit     = CW'(TICKS_SOF);
                bus_drive = 1'b1;
            end
            ST_DATA: begin
                limit     = bit_is_long(cur_bit, lvl_q) ? CW'(TICKS_LONG) : CW'(TICKS_SHORT);
                bus_drive = lvl_q;
                in_ready  = final_bit && !cur_last && !hold_full && !abort;
            end
            ST_EOD: begin
                limit = CW'(TICKS_EOD);
            end
        endcase
        bus_active = bus_drive && !abort;
    end

    // R2: taking a first byte puts the start symbol on the bus
    assert_sof_goes_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid && !abort) |=> (abort || bus_active));

    // R3: the bit after the start symbol is passive
    assert_first_bit_passive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOF && expire && !abort) |=> (abort || !bus_active));

    // R3: the level flips at every bit boundary inside a frame
    assert_level_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && !frame_end && !abort) |=> (abort || (bus_active != $past(bus_active))));

    // R7: after the last bit the bus is passive and no byte is taken
    assert_eod_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && frame_end && !abort) |=> (!bus_active && !in_ready));

    // R8: a byte with no successor and no last mark still closes the frame
    assert_underrun_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && final_bit && !cur_last && !hold_full && !hold_accept && !abort)
        |=> (abort || state_q == ST_EOD));

    // R9: abort leaves the block idle on the next clock
    assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE));

endmodule

// File: tb/sim_vpw_encoder.sv
`timescale 1ns/1ps
module sim_vpw_encoder;

    localparam int T_SHORT = 64;
    localparam int T_LONG  = 128;
    localparam int T_SOF   = 200;
    localparam int T_EOD   = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us;
    logic       abort = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       bus_active;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic lvl;
        int   len;
    } seg_t;

    seg_t q[$];
    int   run;
    logic prev_lvl;
    logic tick_prev;
    logic [7:0] fb [4];

    vpw_encoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_us    (tick_us),
        .abort      (abort),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .bus_active (bus_active)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tick_us <= 1'b0;
        else        tick_us <= ~tick_us;
    end

    // Segment monitor: ticks consumed per bus level
    always @(negedge clk) begin
        if (!rst_n) begin
            run       = 0;
            prev_lvl  = 1'b0;
            tick_prev = 1'b0;
        end else begin
            if (tick_prev) run++;
            if (bus_active !== prev_lvl) begin
                q.push_back('{prev_lvl, run});
                run      = 0;
                prev_lvl = bus_active;
            end
            tick_prev = tick_us;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic lvl, input logic b);
        return (b ^ lvl) ? T_LONG : T_SHORT;
    endfunction

    // Offers one byte, waits for the handshake; for k>0 checks where ready rose (R6)
    task automatic push_byte(input logic [7:0] d, input logic l, input int k);
        in_data  = d;
        in_last  = l;
        in_valid = 1'b1;
        while (!in_ready) step();
        if (k > 0)
            chk(q.size() == 8 * k + 1, "R6", "ready position (segments seen)", q.size(), 8 * k + 1);
        step();
        in_valid = 1'b0;
    endtask

    // Sends n bytes from fb; underrun: first byte unmarked and nothing follows
    task automatic run_frame(input int n, input bit underrun);
        int nb;
        int bad_lvl;
        int bad_len;
        int bad_act;
        int bad_exp;
        q.delete();
        for (int k = 0; k < n; k++)
            push_byte(fb[k], (k == n - 1) && !underrun, k);
        nb = 8 * n;
        while (q.size() < nb + 2) step();
        chk(q[1].lvl == 1'b1 && q[1].len == T_SOF, "R2", "start symbol ticks", q[1].len, T_SOF);
        bad_lvl = 0;
        bad_len = 0;
        bad_act = 0;
        bad_exp = 0;
        for (int j = 0; j < nb; j++) begin
            logic lv;
            logic b;
            lv = j[0];
            b  = fb[j / 8][7 - (j % 8)];
            if (q[j + 2].lvl !== lv) bad_lvl++;
            if (q[j + 2].len != exp_len(lv, b)) begin
                if (bad_len == 0) begin
                    bad_act = q[j + 2].len;
                    bad_exp = exp_len(lv, b);
                end
                bad_len++;
            end
        end
        chk(bad_lvl == 0, "R3", "bits at wrong level", bad_lvl, 0);
        chk(bad_len == 0, "R4/R5", "first wrong bit length", bad_act, bad_exp);
        chk(!in_ready && !bus_active, "R7", "ready/bus at end-of-data start", {in_ready, bus_active}, 0);
        while (!in_ready) step();
        chk(run == T_EOD, "R7", "end-of-data passive ticks", run, T_EOD);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk(bus_active == 1'b0, "R1", "bus after reset", bus_active, 0);
        chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

        // Directed patterns (R4, R5)
        fb[0] = 8'h00; run_frame(1, 1'b0);
        fb[0] = 8'hFF; run_frame(1, 1'b0);
        fb[0] = 8'hA5; fb[1] = 8'h5A; run_frame(2, 1'b0);

        // R8: underrun after a byte not marked last
        fb[0] = 8'h3C;
        run_frame(1, 1'b1);

        // R9: abort in the middle of the start symbol
        q.delete();
        in_data = 8'hC3; in_last = 1'b0; in_valid = 1'b1;
        step();
        in_valid = 1'b0;
        repeat (300) step();
        chk(bus_active == 1'b1, "R2", "bus during start symbol", bus_active, 1);
        abort = 1'b1;
        #1;
        chk(bus_active == 1'b0, "R9", "bus while abort", bus_active, 0);
        chk(in_ready == 1'b0, "R9", "ready while abort", in_ready, 0);
        step();
        abort = 1'b0;
        #1;
        chk(in_ready == 1'b1 && bus_active == 1'b0, "R9", "idle after abort",
            {in_ready, bus_active}, 2);
        step();

        // Recovery plus random frames
        for (int f = 0; f < 12; f++) begin
            int n;
            n = $urandom_range(1, 4);
            for (int k = 0; k < 4; k++) fb[k] = 8'($urandom_range(0, 255));
            repeat ($urandom_range(0, 20)) step();
            run_frame(n, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule